// File: doc/BRIEF.md
# Flash-to-RAM Overlay Address Remapper

This block sits on a 16-bit processor address bus and lets a slice of on-chip RAM stand in for a small part of the flash array. Firmware can then tune constants held in that part of flash in real time, without erasing or reprogramming anything. An 8-bit control register is written from the bus. Its two top bits pick one of three overlay windows, or none. Each window has its own size and its own position.

On every access the block classes the address as flash, RAM or neither. An address that falls inside the active window is an overlay hit. It is sent to RAM at the flash address plus 0xFC00, and flash is not selected. The overlayable RAM at 0xFC00 to 0xFD7F also stays reachable at its own addresses, so both paths lead to the same storage.

The six lower register bits are a clock-doubling flag, a reserved bit, two wait-mode bits and two wait-count bits. They are stored and read back but drive nothing inside this block. A register write changes the decode from the next cycle on. During the write cycle itself, decode still uses the old value.

Top module: `ovl_remap`

## Requirements
- R1: Both a synchronous reset and the hardware-standby input set the control register to 0x08 on the next clock edge, taking priority over a write. At 0x08 no overlay is active.
- R2: A write loads all eight bits of `reg_wdata` into the register, and `reg_rdata` returns them unchanged from the following cycle.
- R3: With register bits [7:6] = 00, no address is an overlay hit. Addresses 0x0000 to 0xEFFF select flash only.
- R4: With bits [7:6] = 01, addresses 0x0080 to 0x00FF hit and map to RAM 0xFC80 to 0xFCFF. Addresses 0x007F and 0x0100 select flash.
- R5: With bits [7:6] = 10, addresses 0x0080 to 0x017F hit and map to RAM 0xFC80 to 0xFD7F. Addresses 0x007F and 0x0180 select flash.
- R6: With bits [7:6] = 11, addresses 0x0000 to 0x007F hit and map to RAM 0xFC00 to 0xFC7F. Address 0x0080 selects flash.
- R7: Addresses 0xFC00 to 0xFD7F select RAM in every mode, with `ram_addr` equal to the bus address. On a hit, `ram_addr` is the bus address plus 0xFC00.
- R8: `flash_sel` is never asserted together with `ovl_hit`, and `flash_sel` and `ram_sel` are never both asserted.
- R9: Addresses 0xF000 to 0xFBFF and 0xFD80 to 0xFFFF select neither flash nor RAM, and `ram_addr` reads 0.
- R10: Register bits [5:0] have no effect on the decode.
- R11: The decode seen in the cycle that writes the register follows the old value. The new value governs from the next cycle. Without a write, reset or standby, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware-standby request; re-initialises the register |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| bus_addr | input | 16 | Processor access address |
| flash_sel | output | 1 | Access goes to flash |
| ram_sel | output | 1 | Access goes to RAM (native or aliased) |
| ovl_hit | output | 1 | Address falls inside the active overlay window |
| ram_addr | output | 16 | RAM address for the access, 0 when `ram_sel` is low |

## Verification
Each window is probed at its first and last address and at the addresses one step outside. An off-by-one edge or a swapped mode encoding therefore shows up as a wrong select or a wrong translated address.

Native RAM addresses and the gaps above flash are read in every mode. This separates the aliased path from the direct path and from "neither".

Writes that set mixed lower bits show that only bits [7:6] steer the decode. A mode change made in the same cycle as an access shows whether the new value leaks into that cycle.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W = 16;
    localparam int CTRL_W = 8;

    localparam logic [ADDR_W-1:0] DEF_RAM_BASE   = 16'hFC00;
    localparam logic [ADDR_W-1:0] DEF_RAM_LAST   = 16'hFD7F;
    localparam logic [ADDR_W-1:0] DEF_FLASH_LAST = 16'hEFFF;
    localparam logic [CTRL_W-1:0] CTRL_RESET     = 8'h08;

    typedef enum logic [1:0] {
        OVL_OFF   = 2'b00,
        OVL_SMALL = 2'b01,
        OVL_WIDE  = 2'b10,
        OVL_LOW   = 2'b11
    } ovl_mode_e;

    typedef struct packed {
        ovl_mode_e  win;
        logic       clk_dbl;
        logic       rsvd;
        logic [1:0] wait_mode;
        logic [1:0] wait_cnt;
    } ctrl_reg_t;

    typedef struct packed {
        logic              flash;
        logic              ram;
        logic              hit;
        logic [ADDR_W-1:0] ram_addr;
    } bus_route_t;

    function automatic logic [ADDR_W-1:0] win_first(input logic [1:0] m);
        case (m)
            2'b01:   return 16'h0080;
            2'b10:   return 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] win_span(input logic [1:0] m);
        case (m)
            2'b01:   return 16'h007F;
            2'b10:   return 16'h00FF;
            default: return 16'h007F;
        endcase
    endfunction

endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_reg_t         ctrl
);

    ctrl_reg_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            ctrl_q <= ctrl_reg_t'(CTRL_RESET);
        end else if (wr_en) begin
            ctrl_q <= ctrl_reg_t'(wdata);
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/ovl_window_decode.sv
module ovl_window_decode
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE = DEF_RAM_BASE
) (
    input  ovl_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] alias_addr
);

    localparam int NUM_MODES = 4;

    logic [NUM_MODES-1:0] in_win;

    assign in_win[0] = 1'b0;

    for (genvar w = 1; w < NUM_MODES; w++) begin : g_win
        localparam logic [1:0] MSEL = 2'(w);
        logic [ADDR_W-1:0] offset;
        assign offset    = addr - win_first(MSEL);
        assign in_win[w] = (offset <= win_span(MSEL));
    end

    assign hit        = in_win[mode];
    assign alias_addr = addr + RAM_BASE;

endmodule

// File: rtl/ovl_route.sv
module ovl_route
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE   = DEF_RAM_BASE,
    parameter logic [ADDR_W-1:0] RAM_LAST   = DEF_RAM_LAST,
    parameter logic [ADDR_W-1:0] FLASH_LAST = DEF_FLASH_LAST
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hit,
    input  logic [ADDR_W-1:0] alias_addr,
    output bus_route_t        route
);

    localparam logic [ADDR_W-1:0] RAM_SPAN = RAM_LAST - RAM_BASE;

    logic [ADDR_W-1:0] ram_off;
    logic              native_ram;
    logic              flash_area;

    assign ram_off    = addr - RAM_BASE;
    assign native_ram = (ram_off <= RAM_SPAN);
    assign flash_area = (addr <= FLASH_LAST);

    always_comb begin
        route = '0;
        if (hit) begin
            route.ram      = 1'b1;
            route.hit      = 1'b1;
            route.ram_addr = alias_addr;
        end else if (native_ram) begin
            route.ram      = 1'b1;
            route.ram_addr = addr;
        end else if (flash_area) begin
            route.flash    = 1'b1;
        end
    end

endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE   = DEF_RAM_BASE,
    parameter logic [ADDR_W-1:0] RAM_LAST   = DEF_RAM_LAST,
    parameter logic [ADDR_W-1:0] FLASH_LAST = DEF_FLASH_LAST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              flash_sel,
    output logic              ram_sel,
    output logic              ovl_hit,
    output logic [ADDR_W-1:0] ram_addr
);

    ctrl_reg_t         ctrl;
    logic              win_hit;
    logic [ADDR_W-1:0] alias_addr;
    bus_route_t        route;

    ovl_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .hw_stby (hw_stby),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .ctrl    (ctrl)
    );

    ovl_window_decode #(
        .RAM_BASE (RAM_BASE)
    ) u_win (
        .mode       (ctrl.win),
        .addr       (bus_addr),
        .hit        (win_hit),
        .alias_addr (alias_addr)
    );

    ovl_route #(
        .RAM_BASE   (RAM_BASE),
        .RAM_LAST   (RAM_LAST),
        .FLASH_LAST (FLASH_LAST)
    ) u_route (
        .addr       (bus_addr),
        .hit        (win_hit),
        .alias_addr (alias_addr),
        .route      (route)
    );

    assign reg_rdata = ctrl;
    assign flash_sel = route.flash;
    assign ram_sel   = route.ram;
    assign ovl_hit   = route.hit;
    assign ram_addr  = route.ram_addr;

endmodule

// File: rtl/ovl_remap_chk.sv
module ovl_remap_chk
    import ovl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hw_stby,
    input logic              reg_wr_en,
    input logic [CTRL_W-1:0] reg_wdata,
    input logic [CTRL_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              flash_sel,
    input logic              ram_sel,
    input logic              ovl_hit,
    input logic [ADDR_W-1:0] ram_addr
);

    assert_no_flash_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
        ovl_hit |-> !flash_sel);

    assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_sel, ram_sel}));

    assert_ram_addr_range_R7: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (ram_addr >= DEF_RAM_BASE && ram_addr <= DEF_RAM_LAST));

    assert_stby_reinit_R1: assert property (@(posedge clk) disable iff (rst)
        $past(hw_stby) |-> reg_rdata == CTRL_RESET);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        $past(reg_wr_en && !hw_stby && !rst) |-> reg_rdata == $past(reg_wdata));

    assert_hold_value_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr_en || hw_stby || rst) |-> $stable(reg_rdata));

    assert_off_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7:6] == 2'b00) |-> !ovl_hit);

    assert_gap_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= 16'hFD80) |-> (!flash_sel && !ram_sel));

endmodule

bind ovl_remap ovl_remap_chk u_chk (.*);

// File: tb/tb_ovl_remap.sv
module tb_ovl_remap;

    typedef struct {
        logic        flash;
        logic        ram;
        logic        hit;
        logic [15:0] raddr;
        logic [7:0]  rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_stby = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] bus_addr = '0;
    logic        flash_sel, ram_sel, ovl_hit;
    logic [15:0] ram_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] model_reg = 8'h08;
    exp_t q[$];

    always #10 clk = ~clk;

    ovl_remap dut (
        .clk(clk), .rst(rst), .hw_stby(hw_stby),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_addr(bus_addr), .flash_sel(flash_sel), .ram_sel(ram_sel),
        .ovl_hit(ovl_hit), .ram_addr(ram_addr)
    );

    function automatic exp_t predict(input logic [7:0] r, input logic [15:0] a, input string tag);
        exp_t e;
        logic [15:0] lo, hi;
        logic on;
        e.flash = 0; e.ram = 0; e.hit = 0; e.raddr = 0; e.rdata = r; e.tag = tag;
        on = 1'b1;
        case (r[7:6])
            2'b01:   begin lo = 16'h0080; hi = 16'h00FF; end
            2'b10:   begin lo = 16'h0080; hi = 16'h017F; end
            2'b11:   begin lo = 16'h0000; hi = 16'h007F; end
            default: begin lo = 16'h0000; hi = 16'h0000; on = 1'b0; end
        endcase
        if (on && a >= lo && a <= hi) begin
            e.ram = 1; e.hit = 1; e.raddr = a + 16'hFC00;
        end else if (a >= 16'hFC00 && a <= 16'hFD7F) begin
            e.ram = 1; e.raddr = a;
        end else if (a < 16'hF000) begin
            e.flash = 1;
        end
        return e;
    endfunction

    task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                          input bit stby, input string tag);
        @(posedge clk);
        #1;
        bus_addr  = a;
        reg_wr_en = wr;
        reg_wdata = wd;
        hw_stby   = stby;
        q.push_back(predict(model_reg, a, tag));
        if (stby)    model_reg = 8'h08;
        else if (wr) model_reg = wd;
    endtask

    task automatic look(input logic [15:0] a, input string tag);
        access(a, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic setreg(input logic [7:0] v, input string tag);
        access(16'hF800, 1'b1, v, 1'b0, tag);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flash_sel !== e.flash || ram_sel !== e.ram || ovl_hit !== e.hit ||
                ram_addr !== e.raddr || reg_rdata !== e.rdata) begin
                failures++;
                $display("FAIL %s addr=%h actual f=%b r=%b h=%b ra=%h rd=%h expected f=%b r=%b h=%b ra=%h rd=%h",
                         e.tag, bus_addr, flash_sel, ram_sel, ovl_hit, ram_addr, reg_rdata,
                         e.flash, e.ram, e.hit, e.raddr, e.rdata);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        look(16'h0080, "R1 reset value no overlay");
        look(16'h0000, "R3 flash low");
        look(16'h0100, "R3 flash mid");
        look(16'hEFFF, "R3 flash top");
        look(16'hFC00, "R7 native ram first");
        look(16'hFD7F, "R7 native ram last");
        look(16'hF000, "R9 gap above flash");
        look(16'hFBFF, "R9 gap below ram");
        look(16'hFD80, "R9 above ram");
        look(16'hFFFF, "R9 top");
        setreg(8'hA5, "R2 write A5");
        look(16'h0000, "R2 readback A5 mode 10");
        setreg(8'h5A, "R2 write 5A");
        look(16'h0000, "R2 readback 5A mode 01");
        setreg(8'h40, "R4 set mode 01");
        look(16'h007F, "R4 below window");
        look(16'h0080, "R4 window first");
        look(16'h00FF, "R4 window last");
        look(16'h0100, "R4 above window");
        look(16'hFCA0, "R7 native in mode 01");
        setreg(8'h7F, "R10 mode 01 low bits set");
        look(16'h00C0, "R10 window unchanged");
        look(16'h0100, "R10 edge unchanged");
        setreg(8'h80, "R5 set mode 10");
        look(16'h007F, "R5 below window");
        look(16'h0080, "R5 window first");
        look(16'h017F, "R5 window last");
        look(16'h0180, "R5 above window");
        look(16'hFD00, "R7 native in mode 10");
        setreg(8'hBF, "R10 mode 10 low bits set");
        look(16'h017F, "R10 wide last unchanged");
        access(16'h0000, 1'b1, 8'hC0, 1'b0, "R11 write cycle uses old mode");
        look(16'h0000, "R6 window first after write");
        look(16'h007F, "R6 window last");
        look(16'h0080, "R6 above window");
        look(16'hFC40, "R7 native in mode 11");
        look(16'hFFF0, "R9 top in mode 11");
        access(16'h0000, 1'b0, 8'h00, 1'b1, "R1 standby cycle");
        look(16'h0000, "R1 standby reinit");
        look(16'h0080, "R8 flash after standby");
        access(16'h0010, 1'b1, 8'hC0, 1'b1, "R1 standby beats write");
        look(16'h0010, "R1 standby priority result");
        look(16'h0010, "R11 value held");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule